// File: doc/BRIEF.md
# Per-Stream Serial Output Advancement

This block launches the bits of several serial output streams ahead of the nominal bit edges. Each stream can be moved earlier by a programmable number of steps. One step is one period of a fast reference clock, intended to be 7.5 ns, so the largest setting of three steps moves a stream 22.5 ns earlier. The step counts absolute clock cycles and not fractions of a bit period, so the same setting gives the same time shift at any serial data rate.

The block receives its inputs in the fast clock domain:
- a frame pulse and a bit-edge pulse, each one cycle wide;
- for every stream, the bit that is to start at that bit edge.

It delays a reference copy of the frame and bit-edge pulses by a fixed three cycles. It then places each stream's data on that reference timeline according to the stream's setting:
- A setting of 0 starts the bit in the same cycle as the delayed bit-edge pulse.
- A setting of k starts the bit k cycles earlier.

The backplane streams and the local streams each have their own bank of settings. Software writes a pending value through a simple write port. That value takes effect only at the next frame pulse.

Top module: `stream_advance`

## Requirements
- R1: While reset is held, `frame_o`, `bit_o`, `bp_ser_o` and `lc_ser_o` are all 0, and every stream's active setting is 0.
- R2: `frame_o` and `bit_o` repeat `frame_i` and `bit_i` exactly 3 cycles later (2**ADV_W-1 cycles in general).
- R3: A stream's line takes the data bit that is present in the cycle `bit_i` is 1 and keeps it until the next `bit_i`. Changes to the data inputs between bit pulses have no effect.
- R4: With an active setting of 0, a stream's new bit appears on its output in the same cycle as the matching `bit_o` pulse.
- R5: With an active setting of k (0 to 3, encoded as the 2-bit value k), a stream's new bit appears k cycles before the matching `bit_o` pulse, for any spacing of the bit pulses.
- R6: A write (`cfg_we`=1) sets the pending value of one stream:
  - `cfg_bank`=0 selects backplane stream `cfg_idx`; `cfg_bank`=1 selects local stream `cfg_idx`.
  - The pending values are copied to the active settings at the clock edge where `frame_i` is 1. A write at that same edge is not included.
  - Between frame pulses, the active settings do not change.
- R7: A local-bank write whose `cfg_idx` is not below NUM_LC (2 or 3 by default) changes no setting.
- R8: Each stream keeps its own setting. A write to one bank leaves the same index in the other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock; one period is one advancement step |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| frame_i | input | 1 | Nominal frame boundary pulse, one cycle wide |
| bit_i | input | 1 | Nominal bit-edge pulse, one cycle wide |
| bp_data_i | input | NUM_BP | Bit to launch on each backplane stream at this bit edge |
| lc_data_i | input | NUM_LC | Bit to launch on each local stream at this bit edge |
| cfg_we | input | 1 | Write strobe for a pending setting |
| cfg_bank | input | 1 | Bank select: 0 backplane, 1 local |
| cfg_idx | input | IDX_W | Stream index within the selected bank |
| cfg_adv | input | ADV_W | Advancement in clock cycles |
| frame_o | output | 1 | Frame pulse on the reference timeline |
| bit_o | output | 1 | Bit-edge pulse on the reference timeline |
| bp_ser_o | output | NUM_BP | Advanced backplane serial outputs |
| lc_ser_o | output | NUM_LC | Advanced local serial outputs |

## Verification
The bench builds the block with its defaults: four backplane streams, two local streams and 2-bit settings. With these values every tap from 0 to 3 cycles is reached, and the local bank sees index codes 2 and 3, which have no register behind them. Bit pulses are spaced 4, 6 and 9 cycles apart, with data that changes every cycle. Settings are written and then held back across bit edges that carry no frame pulse, and one write is made to a single bank. This shows that the advance does not depend on the bit rate, that the data is held between bit edges, that new settings wait for the frame pulse, and that the banks are independent.

// File: rtl/stream_advance_pkg.sv
package stream_advance_pkg;
  typedef enum logic {
    BANK_BACKPLANE = 1'b0,
    BANK_LOCAL     = 1'b1
  } adv_bank_e;
endpackage

// File: rtl/stream_advance_rst_sync.sv
module stream_advance_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_ns = sync_q[1];
endmodule

// File: rtl/stream_advance_cfg_bank.sv
// Pending/active setting pair for one bank of streams.
module stream_advance_cfg_bank #(
  parameter int N     = 4,
  parameter int ADV_W = 2,
  parameter int IDX_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_ns,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [ADV_W-1:0]         wr_val,
  input  logic                     frame_i,
  output logic [N-1:0][ADV_W-1:0]  act_o
);
  logic [N-1:0][ADV_W-1:0] pend_q, pend_d;
  logic [N-1:0][ADV_W-1:0] act_q,  act_d;
  logic                    pend_en, act_en;

  assign pend_en = wr_en;
  assign act_en  = frame_i;

  always_comb begin
    pend_d = pend_q;
    for (int i = 0; i < N; i++) begin
      if (wr_idx == IDX_W'(i)) pend_d[i] = wr_val;
    end
    act_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      if (pend_en) pend_q <= pend_d;
      if (act_en)  act_q  <= act_d;
    end
  end

  assign act_o = act_q;
endmodule

// File: rtl/stream_advance_tap.sv
// One stream: bit hold, history line and tap select.
module stream_advance_tap #(
  parameter int ADV_W = 2
) (
  input  logic             clk,
  input  logic             rst_ns,
  input  logic             bit_i,
  input  logic             data_i,
  input  logic [ADV_W-1:0] adv_i,
  output logic             ser_o
);
  localparam int MAX_ADV = (1 << ADV_W) - 1;
  localparam int NTAP    = MAX_ADV + 1;

  logic               cur_bit;
  logic [MAX_ADV:1]   line_q, line_d;
  logic [NTAP-1:0]    tap_w;
  logic [ADV_W-1:0]   tap_sel;
  logic               out_q, out_d;

  // bit that the nominal timeline carries from this edge on
  assign cur_bit = bit_i ? data_i : line_q[1];

  always_comb begin
    line_d[1] = cur_bit;
    for (int j = 2; j <= MAX_ADV; j++) line_d[j] = line_q[j-1];
  end

  always_comb begin
    tap_w[0] = cur_bit;
    for (int j = 1; j <= MAX_ADV; j++) tap_w[j] = line_q[j];
  end

  // larger advance -> younger history entry
  assign tap_sel = ADV_W'(MAX_ADV) - adv_i;
  assign out_d   = tap_w[tap_sel];

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      line_q <= '0;
      out_q  <= 1'b0;
    end else begin
      line_q <= line_d;
      out_q  <= out_d;
    end
  end

  assign ser_o = out_q;
endmodule

// File: rtl/stream_advance_ref.sv
// Reference timeline: frame and bit pulses delayed by DEPTH registers.
module stream_advance_ref #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_ns,
  input  logic frame_i,
  input  logic bit_i,
  output logic frame_o,
  output logic bit_o
);
  logic [DEPTH-1:0] fr_q, fr_d;
  logic [DEPTH-1:0] bt_q, bt_d;

  always_comb begin
    fr_d[0] = frame_i;
    bt_d[0] = bit_i;
    for (int k = 1; k < DEPTH; k++) begin
      fr_d[k] = fr_q[k-1];
      bt_d[k] = bt_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      fr_q <= '0;
      bt_q <= '0;
    end else begin
      fr_q <= fr_d;
      bt_q <= bt_d;
    end
  end

  assign frame_o = fr_q[DEPTH-1];
  assign bit_o   = bt_q[DEPTH-1];
endmodule

// File: rtl/stream_advance.sv
module stream_advance
  import stream_advance_pkg::*;
#(
  parameter int NUM_BP = 4,
  parameter int NUM_LC = 2,
  parameter int ADV_W  = 2,
  localparam int MAXN  = (NUM_BP > NUM_LC) ? NUM_BP : NUM_LC,
  localparam int IDX_W = (MAXN > 1) ? $clog2(MAXN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_i,
  input  logic              bit_i,
  input  logic [NUM_BP-1:0] bp_data_i,
  input  logic [NUM_LC-1:0] lc_data_i,
  input  logic              cfg_we,
  input  logic              cfg_bank,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ADV_W-1:0]  cfg_adv,
  output logic              frame_o,
  output logic              bit_o,
  output logic [NUM_BP-1:0] bp_ser_o,
  output logic [NUM_LC-1:0] lc_ser_o
);
  localparam int MAX_ADV = (1 << ADV_W) - 1;

  logic                         rst_ns;
  logic                         bp_we, lc_we;
  logic [NUM_BP-1:0][ADV_W-1:0] bp_act;
  logic [NUM_LC-1:0][ADV_W-1:0] lc_act;

  stream_advance_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  assign bp_we = cfg_we && (cfg_bank == BANK_BACKPLANE);
  assign lc_we = cfg_we && (cfg_bank == BANK_LOCAL);

  stream_advance_cfg_bank #(.N(NUM_BP), .ADV_W(ADV_W), .IDX_W(IDX_W)) u_bp_bank (
    .clk     (clk),
    .rst_ns  (rst_ns),
    .wr_en   (bp_we),
    .wr_idx  (cfg_idx),
    .wr_val  (cfg_adv),
    .frame_i (frame_i),
    .act_o   (bp_act)
  );

  stream_advance_cfg_bank #(.N(NUM_LC), .ADV_W(ADV_W), .IDX_W(IDX_W)) u_lc_bank (
    .clk     (clk),
    .rst_ns  (rst_ns),
    .wr_en   (lc_we),
    .wr_idx  (cfg_idx),
    .wr_val  (cfg_adv),
    .frame_i (frame_i),
    .act_o   (lc_act)
  );

  stream_advance_ref #(.DEPTH(MAX_ADV + 1)) u_ref (
    .clk     (clk),
    .rst_ns  (rst_ns),
    .frame_i (frame_i),
    .bit_i   (bit_i),
    .frame_o (frame_o),
    .bit_o   (bit_o)
  );

  for (genvar s = 0; s < NUM_BP; s++) begin : g_bp
    stream_advance_tap #(.ADV_W(ADV_W)) u_tap (
      .clk    (clk),
      .rst_ns (rst_ns),
      .bit_i  (bit_i),
      .data_i (bp_data_i[s]),
      .adv_i  (bp_act[s]),
      .ser_o  (bp_ser_o[s])
    );
  end

  for (genvar s = 0; s < NUM_LC; s++) begin : g_lc
    stream_advance_tap #(.ADV_W(ADV_W)) u_tap (
      .clk    (clk),
      .rst_ns (rst_ns),
      .bit_i  (bit_i),
      .data_i (lc_data_i[s]),
      .adv_i  (lc_act[s]),
      .ser_o  (lc_ser_o[s])
    );
  end
endmodule

// File: rtl/stream_advance_chk.sv
module stream_advance_chk #(
  parameter int NUM_BP = 4,
  parameter int NUM_LC = 2,
  parameter int ADV_W  = 2
) (
  input logic                         clk,
  input logic                         rst_ns,
  input logic                         frame_i,
  input logic                         bit_i,
  input logic                         frame_o,
  input logic                         bit_o,
  input logic [NUM_BP-1:0]            bp_ser_o,
  input logic [NUM_LC-1:0]            lc_ser_o,
  input logic [NUM_BP-1:0][ADV_W-1:0] bp_act,
  input logic [NUM_LC-1:0][ADV_W-1:0] lc_act
);
  localparam int MAX_ADV = (1 << ADV_W) - 1;

  logic [MAX_ADV:0] bit_hist_q;
  logic [MAX_ADV:0] frm_hist_q;
  logic             recent_bit;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      bit_hist_q <= '0;
      frm_hist_q <= '0;
    end else begin
      bit_hist_q <= {bit_hist_q[MAX_ADV-1:0], bit_i};
      frm_hist_q <= {frm_hist_q[MAX_ADV-1:0], frame_i};
    end
  end

  assign recent_bit = |bit_hist_q;

  AST_BIT_REF_LAG: assert property (@(posedge clk) disable iff (!rst_ns)
    bit_o == bit_hist_q[MAX_ADV]); // R2

  AST_FRAME_REF_LAG: assert property (@(posedge clk) disable iff (!rst_ns)
    frame_o == frm_hist_q[MAX_ADV]); // R2

  AST_BP_CHANGE_NEAR_EDGE: assert property (@(posedge clk) disable iff (!rst_ns)
    !$stable(bp_ser_o) |-> recent_bit); // R3

  AST_LC_CHANGE_NEAR_EDGE: assert property (@(posedge clk) disable iff (!rst_ns)
    !$stable(lc_ser_o) |-> recent_bit); // R3

  AST_SETTING_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_ns)
    !$stable({bp_act, lc_act}) |-> $past(frame_i)); // R6
endmodule

bind stream_advance stream_advance_chk #(
  .NUM_BP (NUM_BP),
  .NUM_LC (NUM_LC),
  .ADV_W  (ADV_W)
) u_chk (
  .clk      (clk),
  .rst_ns   (rst_ns),
  .frame_i  (frame_i),
  .bit_i    (bit_i),
  .frame_o  (frame_o),
  .bit_o    (bit_o),
  .bp_ser_o (bp_ser_o),
  .lc_ser_o (lc_ser_o),
  .bp_act   (bp_act),
  .lc_act   (lc_act)
);

// File: tb/stream_advance_bench.sv
`timescale 1ns/1ps
module stream_advance_bench;
  localparam int NUM_BP = 4;
  localparam int NUM_LC = 2;
  localparam int ADV_W  = 2;
  localparam int IDX_W  = 2;
  localparam int LAG    = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              frame_i, bit_i, cfg_we, cfg_bank;
  logic [NUM_BP-1:0] bp_data_i;
  logic [NUM_LC-1:0] lc_data_i;
  logic [IDX_W-1:0]  cfg_idx;
  logic [ADV_W-1:0]  cfg_adv;
  logic              frame_o, bit_o;
  logic [NUM_BP-1:0] bp_ser_o;
  logic [NUM_LC-1:0] lc_ser_o;

  always #4 clk = ~clk;

  stream_advance #(.NUM_BP(NUM_BP), .NUM_LC(NUM_LC), .ADV_W(ADV_W)) u_stream_advance (
    .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .bit_i(bit_i),
    .bp_data_i(bp_data_i), .lc_data_i(lc_data_i), .cfg_we(cfg_we),
    .cfg_bank(cfg_bank), .cfg_idx(cfg_idx), .cfg_adv(cfg_adv),
    .frame_o(frame_o), .bit_o(bit_o), .bp_ser_o(bp_ser_o), .lc_ser_o(lc_ser_o)
  );

  int    checks = 0;
  int    failures = 0;
  string cur_req = "R3";
  bit    finished = 0;

  // behavioural model: history of the nominal line, newest at index 0
  logic [LAG:0]     m_hb [NUM_BP];
  logic [LAG:0]     m_hl [NUM_LC];
  int               m_act_bp [NUM_BP], m_pend_bp [NUM_BP];
  int               m_act_lc [NUM_LC], m_pend_lc [NUM_LC];
  logic [LAG:0]     m_fh, m_bh;

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < NUM_BP; s++) begin m_hb[s] = '0; m_act_bp[s] = 0; m_pend_bp[s] = 0; end
    for (int s = 0; s < NUM_LC; s++) begin m_hl[s] = '0; m_act_lc[s] = 0; m_pend_lc[s] = 0; end
    m_fh = '0; m_bh = '0;
  endtask

  task automatic tick();
    logic nb;
    @(posedge clk); #1;
    for (int s = 0; s < NUM_BP; s++) begin
      nb = bit_i ? bp_data_i[s] : m_hb[s][0];
      m_hb[s] = {m_hb[s][LAG-1:0], nb};
      check(cur_req, $sformatf("bp%0d adv=%0d", s, m_act_bp[s]), bp_ser_o[s], m_hb[s][LAG - m_act_bp[s]]);
    end
    for (int s = 0; s < NUM_LC; s++) begin
      nb = bit_i ? lc_data_i[s] : m_hl[s][0];
      m_hl[s] = {m_hl[s][LAG-1:0], nb};
      check(cur_req, $sformatf("lc%0d adv=%0d", s, m_act_lc[s]), lc_ser_o[s], m_hl[s][LAG - m_act_lc[s]]);
    end
    m_fh = {m_fh[LAG-1:0], frame_i};
    m_bh = {m_bh[LAG-1:0], bit_i};
    check("R2", "frame_o", frame_o, m_fh[LAG]);
    check("R2", "bit_o", bit_o, m_bh[LAG]);
    if (frame_i) begin
      for (int s = 0; s < NUM_BP; s++) m_act_bp[s] = m_pend_bp[s];
      for (int s = 0; s < NUM_LC; s++) m_act_lc[s] = m_pend_lc[s];
    end
    if (cfg_we) begin
      if (!cfg_bank && int'(cfg_idx) < NUM_BP) m_pend_bp[cfg_idx] = int'(cfg_adv);
      if (cfg_bank && int'(cfg_idx) < NUM_LC)  m_pend_lc[cfg_idx] = int'(cfg_adv);
    end
    // data lines change every cycle so holding is exercised (R3)
    bp_data_i = NUM_BP'($urandom());
    lc_data_i = NUM_LC'($urandom());
  endtask

  task automatic write_cfg(bit bank, int idx, int val);
    cfg_we = 1'b1; cfg_bank = bank; cfg_idx = IDX_W'(idx); cfg_adv = ADV_W'(val);
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic run_bits(int nbits, int per, bit with_frame);
    for (int b = 0; b < nbits; b++) begin
      frame_i = with_frame && (b == 0);
      bit_i = 1'b1;
      tick();
      frame_i = 1'b0; bit_i = 1'b0;
      for (int c = 1; c < per; c++) tick();
    end
  endtask

  initial begin
    rst_n = 1'b0; frame_i = 0; bit_i = 0; cfg_we = 0; cfg_bank = 0;
    cfg_idx = '0; cfg_adv = '0; bp_data_i = '1; lc_data_i = '1;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check("R1", "frame_o reset", frame_o, 1'b0);
    check("R1", "bit_o reset", bit_o, 1'b0);
    check("R1", "bp_ser_o reset", |bp_ser_o, 1'b0);
    check("R1", "lc_ser_o reset", |lc_ser_o, 1'b0);
    bp_data_i = '0; lc_data_i = '0;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    // R3 / R4: settings still at their reset value of 0
    cur_req = "R3"; run_bits(8, 4, 1'b1);
    cur_req = "R4"; run_bits(8, 5, 1'b1);

    // R6: pending writes must wait for a frame pulse
    cur_req = "R6";
    write_cfg(0, 0, 3); write_cfg(0, 1, 1); write_cfg(0, 2, 2); write_cfg(0, 3, 0);
    write_cfg(1, 0, 2); write_cfg(1, 1, 3);
    run_bits(6, 5, 1'b0);
    run_bits(6, 5, 1'b1);

    // R5: same settings at several bit spacings
    cur_req = "R5";
    run_bits(8, 4, 1'b1);
    run_bits(6, 6, 1'b1);
    run_bits(5, 9, 1'b1);

    // R7: local index codes with no register behind them
    cur_req = "R7";
    write_cfg(1, 2, 0); write_cfg(1, 3, 1);
    run_bits(6, 5, 1'b1);

    // R8: one bank written, the other bank keeps its values
    cur_req = "R8";
    write_cfg(1, 0, 0); write_cfg(0, 1, 3);
    run_bits(6, 5, 1'b1);
    run_bits(6, 7, 1'b1);

    // R6: change at a frame edge with a write at that same edge
    cur_req = "R6";
    frame_i = 1'b1; bit_i = 1'b1; cfg_we = 1'b1; cfg_bank = 1'b0; cfg_idx = 2'd2; cfg_adv = 2'd0;
    tick();
    frame_i = 1'b0; bit_i = 1'b0; cfg_we = 1'b0;
    repeat (4) tick();
    run_bits(6, 4, 1'b0);
    run_bits(6, 4, 1'b1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R2 watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule